// File: doc/BRIEF.md
# Receive FIFO with Hardware RTS/CTS Flow Control

This block sits between the character receiver of a UART-style serial controller and the CPU. The receiver deposits characters here. Each character carries three error flags for parity, framing and break. The CPU then drains them in arrival order. The FIFO holds sixteen characters. A write that arrives while it is full is discarded, and a sticky overrun flag is raised instead.

The block also handles the modem handshake in hardware, so software takes no part in it. With automatic RTS enabled, the RTS output drops when the fill level reaches a selectable trigger level. It stays low until the CPU has emptied the FIFO. With automatic CTS enabled, the CTS input, passed through a two-stage synchronizer, decides whether the transmitter may begin a new character. A character already being shifted out is never interrupted. The two automatic modes are enabled independently.

Top module: `rxflow_top`

## Requirements
- R1: The FIFO holds up to 16 entries. A write with `wr_en` high while fewer than 16 entries are held is stored, and `fill` always reports the number of held entries (0 to 16).
- R2: `rd_valid` is high whenever at least one entry is held. The read port presents the oldest entry's data on `rd_data` and its flags on `rd_par`, `rd_frm` and `rd_brk`. A read with `rd_en` high removes that entry, so the entries leave in write order.
- R3: A read while the FIFO is empty is ignored: `fill` stays 0 and no entry appears.
- R4: A write while 16 entries are held is dropped and leaves every stored entry unchanged. In the next cycle `overrun` is high. The flag stays high until a successful read in a cycle with no dropped write, and it clears one cycle after that read.
- R5: `trig_sel` picks the trigger level: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14. With `rts_auto_en` high, `rts` is low in any cycle where `fill` is at or above the trigger level.
- R6: With `rts_auto_en` high, once `rts` has dropped it stays low while any entry remains. It returns high in the same cycle that `fill` reaches 0.
- R7: With `rts_auto_en` low, `rts` is held high and any earlier hold-off is forgotten.
- R8: With `cts_auto_en` high, CTS takes effect through a two-stage synchronizer, so `tx_start_ok` follows the value CTS had two clock edges earlier. `tx_start_ok` is high only when `tx_req` is high, `tx_busy` is low and that delayed CTS is high. A character in progress (`tx_busy` high) never sees `tx_start_ok`.
- R9: With `cts_auto_en` low, `tx_start_ok` equals `tx_req` high and `tx_busy` low, whatever the CTS input is.
- R10: Synchronous reset empties the FIFO, clears `overrun`, clears the RTS hold-off and the CTS synchronizer (CTS seen as deasserted), and leaves `rts` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Received character |
| wr_par | input | 1 | Parity error flag of the character |
| wr_frm | input | 1 | Framing error flag of the character |
| wr_brk | input | 1 | Break flag of the character |
| rd_en | input | 1 | CPU removes the oldest entry |
| rd_valid | output | 1 | At least one entry held |
| rd_data | output | 8 | Oldest character |
| rd_par | output | 1 | Parity flag of oldest entry |
| rd_frm | output | 1 | Framing flag of oldest entry |
| rd_brk | output | 1 | Break flag of oldest entry |
| fill | output | 5 | Number of held entries |
| overrun | output | 1 | Sticky flag: a write was dropped |
| rts_auto_en | input | 1 | Enable hardware RTS control |
| trig_sel | input | 2 | Trigger level select |
| rts | output | 1 | Request to send, high = ready to receive |
| cts_auto_en | input | 1 | Enable hardware CTS gating |
| cts | input | 1 | Clear to send, high = peer ready |
| tx_req | input | 1 | Transmitter has a character waiting |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_start_ok | output | 1 | Transmitter may start the waiting character |

## Verification
The in-line assertions check these rules on every cycle:
- the fill level never exceeds the depth;
- a read of an empty FIFO or a write into a full one changes nothing stored, and a dropped write raises the overrun flag;
- RTS is low at or above the trigger level, stays low until the FIFO is empty, and is high when automatic RTS is off;
- no start permit is given to a busy transmitter, or while the delayed CTS is low.

First-in first-out ordering of data and flags, the exact cycle the overrun flag clears, and the hysteresis across all four trigger levels need the bench's reference model. The model compares every output on every clock while the bench fills, overfills, drains and mixes reads with writes.

// File: rtl/rxflow_pkg.sv
package rxflow_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'd0,
        TRIG_QUARTER = 2'd1,
        TRIG_HALF    = 2'd2,
        TRIG_NEAR    = 2'd3
    } trig_sel_e;

    function automatic int unsigned trig_level(trig_sel_e sel, int unsigned depth);
        case (sel)
            TRIG_ONE:     return 1;
            TRIG_QUARTER: return depth / 4;
            TRIG_HALF:    return depth / 2;
            default:      return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxflow_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  rx_entry_t     wr_entry,
    input  logic          rd_en,
    output rx_entry_t     rd_entry,
    output logic          empty,
    output logic [CW-1:0] fill,
    output logic          overrun
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          full, do_wr, do_rd, drop;

    assign full  = (count == FULL);
    assign empty = (count == '0);
    assign do_wr = wr_en && !full;
    assign drop  = wr_en && full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (drop)       overrun <= 1'b1;
            else if (do_rd) overrun <= 1'b0;
        end
    end

    assign rd_entry = mem[rptr];
    assign fill     = count;

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL);

    a_r3_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !wr_en) |=> empty);

    a_r4_full_write_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> (fill == FULL) && $stable(rd_entry));

    a_r4_overrun_raised: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> overrun);

endmodule

// File: rtl/rxf_rts.sv
module rxf_rts
    import rxflow_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_en,
    input  trig_sel_e     trig_sel,
    input  logic [CW-1:0] fill,
    output logic          rts
);

    logic [CW-1:0] level;
    logic          at_trig, hold_q, stay_off;

    assign level    = CW'(trig_level(trig_sel, DEPTH));
    assign at_trig  = (fill >= level);
    assign stay_off = hold_q && (fill != '0);

    always_ff @(posedge clk) begin
        if (rst || !auto_en) hold_q <= 1'b0;
        else if (at_trig)    hold_q <= 1'b1;
        else if (fill == '0) hold_q <= 1'b0;
    end

    assign rts = !auto_en || !(at_trig || stay_off);

    a_r5_drop_at_level: assert property (@(posedge clk) disable iff (rst)
        (auto_en && fill >= level) |-> !rts);

    a_r6_hold_until_empty: assert property (@(posedge clk) disable iff (rst)
        (auto_en && $past(auto_en) && !$past(rts) && fill != '0) |-> !rts);

    a_r6_release_on_empty: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> rts);

    a_r7_manual_high: assert property (@(posedge clk) disable iff (rst)
        !auto_en |-> rts);

endmodule

// File: rtl/rxf_txgate.sv
module rxf_txgate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic cts,
    input  logic tx_req,
    input  logic tx_busy,
    output logic start_ok
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   cts_seen;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], cts};
    end

    assign cts_seen = sync_q[SYNC_STAGES-1];
    assign start_ok = tx_req && !tx_busy && (!auto_en || cts_seen);

    a_r8_never_while_busy: assert property (@(posedge clk) disable iff (rst)
        tx_busy |-> !start_ok);

    a_r9_ungated: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && tx_req && !tx_busy) |-> start_ok);

    generate
        if (SYNC_STAGES == 2) begin : g_two_stage_check
            a_r8_cts_blocks: assert property (@(posedge clk) disable iff (rst)
                (auto_en && !$past(cts, 2)) |-> !start_ok);
        end
    endgenerate

endmodule

// File: rtl/rxflow_top.sv
module rxflow_top
    import rxflow_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_par,
    input  logic              wr_frm,
    input  logic              wr_brk,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_par,
    output logic              rd_frm,
    output logic              rd_brk,
    output logic [CW-1:0]     fill,
    output logic              overrun,
    input  logic              rts_auto_en,
    input  logic [1:0]        trig_sel,
    output logic              rts,
    input  logic              cts_auto_en,
    input  logic              cts,
    input  logic              tx_req,
    input  logic              tx_busy,
    output logic              tx_start_ok
);

    rx_entry_t wr_entry, rd_entry;
    logic      empty;

    assign wr_entry = '{brk: wr_brk, frm: wr_frm, par: wr_par, data: wr_data};

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .rd_en    (rd_en),
        .rd_entry (rd_entry),
        .empty    (empty),
        .fill     (fill),
        .overrun  (overrun)
    );

    assign rd_valid = !empty;
    assign rd_data  = rd_entry.data;
    assign rd_par   = rd_entry.par;
    assign rd_frm   = rd_entry.frm;
    assign rd_brk   = rd_entry.brk;

    rxf_rts #(.DEPTH(DEPTH)) u_rts (
        .clk      (clk),
        .rst      (rst),
        .auto_en  (rts_auto_en),
        .trig_sel (trig_sel_e'(trig_sel)),
        .fill     (fill),
        .rts      (rts)
    );

    rxf_txgate #(.SYNC_STAGES(SYNC_STAGES)) u_txgate (
        .clk      (clk),
        .rst      (rst),
        .auto_en  (cts_auto_en),
        .cts      (cts),
        .tx_req   (tx_req),
        .tx_busy  (tx_busy),
        .start_ok (tx_start_ok)
    );

endmodule

// File: tb/tb_rxflow_top.sv
module tb_rxflow_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int MAX_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 0, wr_par = 0, wr_frm = 0, wr_brk = 0, rd_en = 0;
    logic [7:0] wr_data = 0;
    logic       rd_valid, rd_par, rd_frm, rd_brk, overrun, rts, tx_start_ok;
    logic [7:0] rd_data;
    logic [4:0] fill;
    logic       rts_auto_en = 0, cts_auto_en = 0, cts = 0, tx_req = 0, tx_busy = 0;
    logic [1:0] trig_sel = 0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [10:0] mq[$];
    bit m_ovr, m_hold, m_c1, m_c2;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxflow_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_par(wr_par), .wr_frm(wr_frm), .wr_brk(wr_brk), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(rd_par),
        .rd_frm(rd_frm), .rd_brk(rd_brk), .fill(fill), .overrun(overrun),
        .rts_auto_en(rts_auto_en), .trig_sel(trig_sel), .rts(rts),
        .cts_auto_en(cts_auto_en), .cts(cts), .tx_req(tx_req),
        .tx_busy(tx_busy), .tx_start_ok(tx_start_ok)
    );

    function automatic int trig(int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mq.delete();
        m_ovr = 0; m_hold = 0; m_c1 = 0; m_c2 = 0;
    endtask

    task automatic cyc();
        int  n;
        bit  ev, er;
        #1;
        n  = mq.size();
        ev = (n != 0);
        chk("R2 rd_valid", int'(rd_valid), int'(ev));
        if (ev) chk("R2 oldest entry", int'({rd_brk, rd_frm, rd_par, rd_data}), int'(mq[0]));
        chk("R1 fill", int'(fill), n);
        chk("R4 overrun", int'(overrun), int'(m_ovr));
        er = !rts_auto_en || !((n >= trig(trig_sel)) || (m_hold && n != 0));
        chk("R5 R6 R7 rts", int'(rts), int'(er));
        chk("R8 R9 tx_start_ok", int'(tx_start_ok),
            int'(tx_req && !tx_busy && (!cts_auto_en || m_c2)));
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            bit full_now = (n == DEPTH);
            if (!rts_auto_en)           m_hold = 0;
            else if (n >= trig(trig_sel)) m_hold = 1;
            else if (n == 0)           m_hold = 0;
            if (wr_en && full_now)  m_ovr = 1;
            else if (rd_en && n != 0) m_ovr = 0;
            if (rd_en && n != 0) void'(mq.pop_front());
            if (wr_en && !full_now) mq.push_back({wr_brk, wr_frm, wr_par, wr_data});
            m_c2 = m_c1;
            m_c1 = cts;
        end
        @(negedge clk);
    endtask

    task automatic put(int v);
        wr_en = 1; wr_data = 8'(v * 37 + 5);
        wr_par = v[0]; wr_frm = v[1]; wr_brk = v[2];
        rd_en = 0;
        cyc();
        wr_en = 0;
    endtask

    task automatic take();
        rd_en = 1; wr_en = 0;
        cyc();
        rd_en = 0;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) cyc();
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        rts_auto_en = 1; cts_auto_en = 1; trig_sel = 2'd3;
        cyc();
        // R10 reset state
        chk("R10 fill after reset", int'(fill), 0);
        chk("R10 rts after reset", int'(rts), 1);
        chk("R10 overrun after reset", int'(overrun), 0);
        rst = 0;
        idle(2);

        // R1 fill to capacity, R5 RTS drops at 14
        for (int i = 0; i < DEPTH; i++) put(i);
        chk("R1 full at sixteen", int'(fill), DEPTH);
        chk("R5 rts low when full", int'(rts), 0);
        // R4 writes into full FIFO are dropped
        put(99); put(100);
        chk("R4 overrun set", int'(overrun), 1);
        chk("R4 oldest kept", int'(rd_data), 5);
        // simultaneous read and write while full: write dropped
        wr_en = 1; wr_data = 8'hAA; rd_en = 1; cyc(); wr_en = 0; rd_en = 0;
        chk("R4 overrun stays on dropped write", int'(overrun), 1);
        // R6: partial drain keeps RTS low
        for (int i = 0; i < 8; i++) take();
        chk("R6 rts still low", int'(rts), 0);
        chk("R4 overrun cleared by read", int'(overrun), 0);
        while (fill != 0) take();
        chk("R6 rts back high at empty", int'(rts), 1);
        // R3 reads on empty
        take(); take();
        chk("R3 empty read ignored", int'(fill), 0);

        // R5 each trigger level
        for (int s = 0; s < 3; s++) begin
            trig_sel = 2'(s);
            for (int i = 0; i < trig(s) + 1; i++) put(i + s * 3);
            chk("R5 rts low at level", int'(rts), 0);
            take();
            chk("R6 rts low after one read", int'(rts), 0);
            while (fill != 0) take();
        end

        // mixed read and write
        trig_sel = 2'd2;
        for (int i = 0; i < 5; i++) put(i + 40);
        for (int i = 0; i < 6; i++) begin
            wr_en = 1; wr_data = 8'(i * 11); wr_par = i[0]; wr_frm = 0; wr_brk = i[1];
            rd_en = 1; cyc();
        end
        wr_en = 0; rd_en = 0;
        while (fill != 0) take();

        // R7 auto RTS disabled
        rts_auto_en = 0;
        for (int i = 0; i < 10; i++) put(i + 60);
        chk("R7 rts high when manual", int'(rts), 1);
        rts_auto_en = 1; cyc();
        chk("R5 rts low on re-enable", int'(rts), 0);
        while (fill != 0) take();

        // R8 CTS gating with synchronizer delay
        tx_req = 1; cts = 0; idle(3);
        chk("R8 blocked with cts low", int'(tx_start_ok), 0);
        cts = 1; cyc();
        chk("R8 one edge not enough", int'(tx_start_ok), 0);
        cyc();
        chk("R8 allowed after two edges", int'(tx_start_ok), 1);
        tx_busy = 1; cyc();
        chk("R8 busy never permitted", int'(tx_start_ok), 0);
        cts = 0; idle(3); tx_busy = 0; cyc();
        chk("R8 cts drop blocks next start", int'(tx_start_ok), 0);
        for (int i = 0; i < 12; i++) begin
            cts = i[0] ^ i[2]; tx_busy = i[1] & i[3]; tx_req = !(i == 5);
            cyc();
        end
        // R9 auto CTS disabled
        cts_auto_en = 0; cts = 0; tx_busy = 0; tx_req = 1; cyc();
        chk("R9 ungated permit", int'(tx_start_ok), 1);
        tx_busy = 1; cyc();
        chk("R9 busy blocks", int'(tx_start_ok), 0);
        tx_busy = 0; tx_req = 0; cyc();

        // R10 reset in the middle of activity
        cts_auto_en = 1; cts = 1; idle(3);
        for (int i = 0; i < 15; i++) put(i);
        rst = 1; cyc(); rst = 0;
        chk("R10 fill cleared", int'(fill), 0);
        chk("R10 rts high", int'(rts), 1);
        tx_req = 1; cyc();
        chk("R10 cts sync cleared", int'(tx_start_ok), 0);
        idle(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule